// File: doc/BRIEF.md
# Memory Request Partition Label Generator

This block tags each memory request with a partition label: a 16-bit partition ID, an 8-bit monitoring group, and a flag that says whether the partition ID is virtual. For every request it takes two partition register words as inputs, one for the least privileged level and one for the level above it. It also takes the request kind (instruction fetch or load/store), the current privilege level, and a set of hypervisor control bits. From these it decides which register word supplies the fields and which half of that word applies.

Under hypervisor control, the level-1 word can stand in for the level-0 word. The virtual flag tells a later stage that the partition ID must be translated into a physical one. This block does not do that translation. The label is registered and comes out one cycle after the request, with its own valid strobe.

Both register words use the same layout. Bits [15:0] hold the instruction partition ID. Bits [31:16] hold the data partition ID. Bits [39:32] hold the instruction monitoring group. Bits [47:40] hold the data monitoring group.

Top module: `part_label_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `lbl_valid`, `lbl_virtual`, `lbl_partid` and `lbl_pmg` are all zero.
- R2: `lbl_valid` is high in the cycle after `req_valid` was sampled high, and low in the cycle after it was sampled low.
- R3: At level 0, when the substitution condition of R4 is false, the label fields come from `l0_word`.
- R4: At level 0, the label fields come from `l1_word` when all of `el2_enabled`, `virt_present` and `hyp_plug` are 1 and `hyp_tge` is 0.
- R5: When `req_is_instr` = 1, the label takes the partition ID from bits [15:0] and the monitoring group from bits [39:32] of the chosen word. When `req_is_instr` = 0, it takes bits [31:16] and [47:40].
- R6: At level 0, `lbl_virtual` is 1 exactly when `el2_enabled`, `virt_present` and `hyp_vmap_en` are all 1 and at least one of `hyp_host_mode` and `hyp_tge` is 0.
- R7: At any level other than 0, the label fields come from `l1_word` and `lbl_virtual` is 0, whatever the control bits are.
- R8: A cycle with `req_valid` low leaves `lbl_partid`, `lbl_pmg` and `lbl_virtual` unchanged, even when the register words change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_is_instr | input | 1 | 1 for an instruction fetch, 0 for a load or store |
| cur_level | input | 2 | Privilege level of the request, 0 being the least privileged |
| el2_enabled | input | 1 | Level 2 is present and enabled |
| virt_present | input | 1 | Partition virtualization is implemented |
| hyp_host_mode | input | 1 | Hypervisor host-mode enable |
| hyp_tge | input | 1 | Hypervisor trap-general-exception bit |
| hyp_plug | input | 1 | The level-1 word applies to level-0 requests |
| hyp_vmap_en | input | 1 | Level-0 partition IDs are virtual |
| l0_word | input | 48 | Level-0 partition register word |
| l1_word | input | 48 | Level-1 partition register word |
| lbl_valid | output | 1 | The label is valid |
| lbl_partid | output | 16 | Partition ID of the label |
| lbl_pmg | output | 8 | Monitoring group of the label |
| lbl_virtual | output | 1 | The partition ID needs virtual-to-physical translation |

## Verification
Register substitution and the virtual flag are decided in the same cycle, from overlapping control bits. `hyp_tge` = 0 enables both of them, while `hyp_host_mode` affects only the flag. The bench sweeps all 64 combinations of the six control bits, for every level and both request kinds. This provokes cycles where both decisions are active, where only one is active, and where neither is. Each label is compared field by field with a value computed from the requirements. A mix-up between the two conditions therefore shows up either as a wrong source word or as a wrong flag.

// File: rtl/part_label_pkg.sv
package part_label_pkg;

    localparam int unsigned PARTID_W = 16;
    localparam int unsigned PMG_W    = 8;
    localparam int unsigned LEVEL_W  = 2;

    // Hypervisor-side control bits, grouped for the decision logic
    typedef struct packed {
        logic el2_en;
        logic virt_present;
        logic host_mode;
        logic tge;
        logic plug;
        logic vmap_en;
    } hyp_ctrl_t;

    typedef enum logic {
        SRC_LOW  = 1'b0,
        SRC_HIGH = 1'b1
    } src_sel_e;

endpackage

// File: rtl/label_ctrl.sv
module label_ctrl
    import part_label_pkg::*;
(
    input  hyp_ctrl_t ctrl,
    input  logic      level_is_zero,
    output src_sel_e  src_sel,
    output logic      virt_flag
);

    logic sub_ok;
    logic vmap_ok;

    always_comb begin
        sub_ok  = ctrl.el2_en & ctrl.virt_present & ctrl.plug & ~ctrl.tge;
        vmap_ok = ctrl.el2_en & ctrl.virt_present & ctrl.vmap_en
                  & (~ctrl.host_mode | ~ctrl.tge);
        if (!level_is_zero) begin
            src_sel   = SRC_HIGH;
            virt_flag = 1'b0;
        end else begin
            src_sel   = sub_ok ? SRC_HIGH : SRC_LOW;
            virt_flag = vmap_ok;
        end
    end

    // R4: substitution never happens at level 0 while tge is set
    always_comb begin
        p_no_sub_with_tge_r4 : assert (!(level_is_zero && ctrl.tge && src_sel == SRC_HIGH));
    end

    // R6: virtual flag requires level 2 to be enabled
    always_comb begin
        p_virt_needs_el2_r6 : assert (!(virt_flag && !ctrl.el2_en));
    end

endmodule

// File: rtl/label_pick.sv
module label_pick #(
    parameter int unsigned PARTID_W = 16,
    parameter int unsigned PMG_W    = 8,
    localparam int unsigned WORD_W  = 2 * PARTID_W + 2 * PMG_W,
    localparam int unsigned N_KIND  = 2
) (
    input  logic [WORD_W-1:0]   word,
    input  logic                is_instr,
    output logic [PARTID_W-1:0] partid,
    output logic [PMG_W-1:0]    pmg
);

    // kind 0: instruction, kind 1: data
    logic [PARTID_W-1:0] pid_f [N_KIND];
    logic [PMG_W-1:0]    pmg_f [N_KIND];

    for (genvar k = 0; k < N_KIND; k++) begin : g_kind
        assign pid_f[k] = word[k*PARTID_W +: PARTID_W];
        assign pmg_f[k] = word[N_KIND*PARTID_W + k*PMG_W +: PMG_W];
    end

    always_comb begin
        partid = is_instr ? pid_f[0] : pid_f[1];
        pmg    = is_instr ? pmg_f[0] : pmg_f[1];
    end

endmodule

// File: rtl/part_label_gen.sv
module part_label_gen
    import part_label_pkg::*;
#(
    parameter int unsigned P_PARTID_W = PARTID_W,
    parameter int unsigned P_PMG_W    = PMG_W,
    parameter int unsigned P_LEVEL_W  = LEVEL_W,
    localparam int unsigned WORD_W    = 2 * P_PARTID_W + 2 * P_PMG_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_is_instr,
    input  logic [P_LEVEL_W-1:0]  cur_level,
    input  logic                  el2_enabled,
    input  logic                  virt_present,
    input  logic                  hyp_host_mode,
    input  logic                  hyp_tge,
    input  logic                  hyp_plug,
    input  logic                  hyp_vmap_en,
    input  logic [WORD_W-1:0]     l0_word,
    input  logic [WORD_W-1:0]     l1_word,
    output logic                  lbl_valid,
    output logic [P_PARTID_W-1:0] lbl_partid,
    output logic [P_PMG_W-1:0]    lbl_pmg,
    output logic                  lbl_virtual
);

    typedef struct packed {
        logic                  valid;
        logic                  virt;
        logic [P_PMG_W-1:0]    pmg;
        logic [P_PARTID_W-1:0] partid;
    } lbl_state_t;

    hyp_ctrl_t           ctrl;
    src_sel_e            src_sel;
    logic                virt_flag;
    logic [WORD_W-1:0]   src_word;
    logic [P_PARTID_W-1:0] pick_partid;
    logic [P_PMG_W-1:0]    pick_pmg;
    lbl_state_t          state_d, state_q;

    assign ctrl = '{el2_en:       el2_enabled,
                    virt_present: virt_present,
                    host_mode:    hyp_host_mode,
                    tge:          hyp_tge,
                    plug:         hyp_plug,
                    vmap_en:      hyp_vmap_en};

    label_ctrl u_ctrl (
        .ctrl          (ctrl),
        .level_is_zero (cur_level == '0),
        .src_sel       (src_sel),
        .virt_flag     (virt_flag)
    );

    assign src_word = (src_sel == SRC_HIGH) ? l1_word : l0_word;

    label_pick #(
        .PARTID_W (P_PARTID_W),
        .PMG_W    (P_PMG_W)
    ) u_pick (
        .word     (src_word),
        .is_instr (req_is_instr),
        .partid   (pick_partid),
        .pmg      (pick_pmg)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = req_valid;
        if (req_valid) begin
            state_d.partid = pick_partid;
            state_d.pmg    = pick_pmg;
            state_d.virt   = virt_flag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign lbl_valid   = state_q.valid;
    assign lbl_partid  = state_q.partid;
    assign lbl_pmg     = state_q.pmg;
    assign lbl_virtual = state_q.virt;

    p_valid_follows_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> lbl_valid);
    p_idle_follows_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !lbl_valid);
    p_upper_not_virtual_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_level != '0) |=> !lbl_virtual);
    p_hold_label_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(lbl_partid) && $stable(lbl_pmg) && $stable(lbl_virtual)));

endmodule

// File: tb/sim_part_label_gen.sv
module sim_part_label_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_is_instr = 1'b0;
    logic [1:0]  cur_level = 2'd0;
    logic        el2_enabled = 1'b0, virt_present = 1'b0, hyp_host_mode = 1'b0;
    logic        hyp_tge = 1'b0, hyp_plug = 1'b0, hyp_vmap_en = 1'b0;
    logic [47:0] l0_word = '0, l1_word = '0;
    logic        lbl_valid, lbl_virtual;
    logic [15:0] lbl_partid;
    logic [7:0]  lbl_pmg;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    part_label_gen u0 (
        .clk, .rst_n, .req_valid, .req_is_instr, .cur_level,
        .el2_enabled, .virt_present, .hyp_host_mode, .hyp_tge,
        .hyp_plug, .hyp_vmap_en, .l0_word, .l1_word,
        .lbl_valid, .lbl_partid, .lbl_pmg, .lbl_virtual
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: outputs zero during reset
        repeat (3) @(negedge clk);
        check("R1", "valid", {31'd0, lbl_valid}, 32'd0);
        check("R1", "fields", {7'd0, lbl_virtual, lbl_pmg, lbl_partid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after release", {31'd0, lbl_valid}, 32'd0);
        check("R1", "fields after release", {7'd0, lbl_virtual, lbl_pmg, lbl_partid}, 32'd0);

        for (int c = 0; c < 64; c++) begin
            for (int lv = 0; lv < 4; lv++) begin
                for (int k = 0; k < 2; k++) begin
                    logic e2, vp, hm, tg, pl, vm, use_hi, exp_v;
                    logic [47:0] w0, w1, ws;
                    logic [15:0] exp_pid;
                    logic [7:0]  exp_pmg;
                    string tag;
                    {e2, vp, hm, tg, pl, vm} = 6'(c);
                    w0 = {8'(8'hA1 + c), 8'(8'h52 + lv), 16'(16'h3000 + c*7 + k), 16'(16'h4000 + c*3 + lv)};
                    w1 = {8'(8'hC3 + lv), 8'(8'h1D + c), 16'(16'h9000 + c*5 + lv), 16'(16'h7000 + c*11 + k)};
                    @(negedge clk);
                    {el2_enabled, virt_present, hyp_host_mode, hyp_tge, hyp_plug, hyp_vmap_en} = 6'(c);
                    cur_level = 2'(lv);
                    req_is_instr = k[0];
                    l0_word = w0;
                    l1_word = w1;
                    req_valid = 1'b1;
                    use_hi = (lv != 0) || (e2 && vp && pl && !tg);
                    exp_v  = (lv == 0) && e2 && vp && vm && (!hm || !tg);
                    ws = use_hi ? w1 : w0;
                    exp_pid = k[0] ? ws[15:0]  : ws[31:16];
                    exp_pmg = k[0] ? ws[39:32] : ws[47:40];
                    tag = (lv != 0) ? "R7" : (use_hi ? "R4" : "R3");
                    @(negedge clk);
                    req_valid = 1'b0;
                    check("R2", "valid", {31'd0, lbl_valid}, 32'd1);
                    check(tag, "partid (R5 field)", {16'd0, lbl_partid}, {16'd0, exp_pid});
                    check(tag, "pmg (R5 field)", {24'd0, lbl_pmg}, {24'd0, exp_pmg});
                    check((lv != 0) ? "R7" : "R6", "virtual", {31'd0, lbl_virtual}, {31'd0, exp_v});
                end
            end
        end

        // R8: idle cycles keep the label while register words change
        begin
            logic [15:0] hp;
            logic [7:0]  hg;
            logic        hv;
            @(negedge clk);
            {el2_enabled, virt_present, hyp_host_mode, hyp_tge, hyp_plug, hyp_vmap_en} = 6'b110001;
            cur_level = 2'd0;
            req_is_instr = 1'b0;
            l0_word = 48'h5A_6B_1234_5678;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            hp = lbl_partid; hg = lbl_pmg; hv = lbl_virtual;
            check("R6", "virtual set for hold test", {31'd0, hv}, 32'd1);
            check("R3", "data partid for hold test", {16'd0, hp}, 32'h1234);
            l0_word = 48'hFF_EE_DDDD_CCCC;
            l1_word = 48'h11_22_3333_4444;
            hyp_vmap_en = 1'b0;
            @(negedge clk);
            check("R2", "idle valid", {31'd0, lbl_valid}, 32'd0);
            check("R8", "partid held", {16'd0, lbl_partid}, {16'd0, hp});
            check("R8", "pmg held", {24'd0, lbl_pmg}, {24'd0, hg});
            check("R8", "virtual held", {31'd0, lbl_virtual}, {31'd0, hv});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule